// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block is a row of functional flip-flops, each fronted by a two-way input select, linked into one serial shift path. A small controller runs the test sequence on that path. When a start strobe arrives, it loads a stimulus pattern bit by bit. It then gives the flip-flops one functional clock to latch the logic's response. After that it shifts the response out, and while it does so it shifts in the next stimulus. Once the last response has been unloaded it reports completion.

Outside a test run, the flip-flops behave as ordinary state registers fed by the functional next-state vector. An extra flip-flop runs on the free-running clock and samples a clock-gate enable. A gate enable that is stuck low can therefore be observed even when the gated logic never toggles.

Top module: `scan_seq_top`

## Requirements
- R1: While `rst_ni` is low, every chain bit is 0, `scan_en_o`, `scan_valid_o`, `done_o` and `cg_obs_o` are 0, and the controller is idle.
- R2: Whenever `scan_en_o` is 0, each chain bit loads the matching bit of `func_d_i` on the next clock, and `scan_in_i` has no effect.
- R3: Whenever `scan_en_o` is 1, on each clock bit 0 takes `scan_in_i` and bit i takes bit i-1. `scan_out_o` always shows bit CHAIN_LEN-1.
- R4: Each load holds `scan_en_o` at 1 for exactly CHAIN_LEN clocks. The bit driven in the first load clock ends in bit CHAIN_LEN-1, so the chain then equals the pattern that was supplied most significant bit first.
- R5: After each load, `scan_en_o` is 0 for exactly one clock. That clock latches `func_d_i` into the chain, and `scan_en_o` is 1 again on the next clock.
- R6: The response of pattern k leaves on `scan_out_o`, bit CHAIN_LEN-1 first, during the same CHAIN_LEN clocks that load pattern k+1. The last response is unloaded in a final CHAIN_LEN-clock shift.
- R7: `scan_valid_o` is 0 throughout the first load and 1 in every later shift clock, including the final unload. It is never 1 while `scan_en_o` is 0.
- R8: A run of P patterns, counted from the clock that samples `start_i`, keeps `done_o` low for exactly (P+1)·CHAIN_LEN + P clocks.
- R9: `done_o` stays 1 with `scan_en_o` at 0 until the next `start_i`. A start in that state begins a new run on the next clock.
- R10: A start with `pat_count_i` equal to 0 goes straight to the done state with no shift clock.
- R11: `cg_obs_o` takes the value `cg_en_i` had on every clock, in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scan_in_i | input | 1 | Serial stimulus into chain bit 0 |
| start_i | input | 1 | Starts a test run when idle or done |
| pat_count_i | input | CNT_W | Number of patterns in the run |
| func_d_i | input | CHAIN_LEN | Functional next-state vector |
| cg_en_i | input | 1 | Clock-gate enable under observation |
| scan_out_o | output | 1 | Serial response from chain bit CHAIN_LEN-1 |
| scan_valid_o | output | 1 | Marks scan_out_o as carrying a response bit |
| scan_en_o | output | 1 | 1 selects shift, 0 selects functional load |
| done_o | output | 1 | Run complete |
| chain_q_o | output | CHAIN_LEN | Parallel chain state |
| cg_obs_o | output | 1 | Observation flop output for cg_en_i |

## Verification
The bench uses patterns whose end bits differ, so that a chain stitched in reverse, or an unload that starts at bit 0, gives a wrong stream on the first bit. It counts the clocks from start to done for one and for three patterns. A controller that skips the overlap, or that holds capture for two clocks, misses the (P+1)·N+P total. It checks that the valid flag stays low for the whole first load and high for the final unload, which exposes an off-by-one in the first-load marker. It also starts a run from the done state, starts a run with a zero count, and holds the gate enable low to confirm that the observation flop reports the stuck value.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPTURE,
    ST_UNLOAD,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic se_i,
  input  logic d_i,
  input  logic si_i,
  output logic q_o
);
  logic d_sel;

  assign d_sel = se_i ? si_i : d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_sel;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 se_i,
  input  logic                 si_i,
  input  logic [CHAIN_LEN-1:0] d_i,
  output logic [CHAIN_LEN-1:0] q_o,
  output logic                 so_o
);
  logic [CHAIN_LEN-1:0] link;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign link[i] = si_i;
    end else begin : g_body
      assign link[i] = q_o[i-1];
    end
    scan_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .se_i   (se_i),
      .d_i    (d_i[i]),
      .si_i   (link[i]),
      .q_o    (q_o[i])
    );
  end

  assign so_o = q_o[CHAIN_LEN-1];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pat_count_i,
  output logic             scan_en_o,
  output logic             valid_o,
  output logic             done_o
);
  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);

  seq_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] left_q;
  logic             first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            bit_q   <= '0;
            left_q  <= pat_count_i;
            first_q <= 1'b1;
            state_q <= (pat_count_i == '0) ? ST_DONE : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (bit_q == LAST_BIT) begin
            bit_q   <= '0;
            state_q <= ST_CAPTURE;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_CAPTURE: begin
          left_q  <= left_q - 1'b1;
          first_q <= 1'b0;
          state_q <= (left_q == CNT_W'(1)) ? ST_UNLOAD : ST_SHIFT;
        end
        ST_UNLOAD: begin
          if (bit_q == LAST_BIT) begin
            bit_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_en_o = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
  // first load carries no response
  assign valid_o   = scan_en_o && !first_q;
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/cg_observer.sv
module cg_observer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic obs_o
);
  // runs on the ungated clock so a dead enable still shows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) obs_o <= 1'b0;
    else         obs_o <= en_i;
  end
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scan_in_i,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     pat_count_i,
  input  logic [CHAIN_LEN-1:0] func_d_i,
  input  logic                 cg_en_i,
  output logic                 scan_out_o,
  output logic                 scan_valid_o,
  output logic                 scan_en_o,
  output logic                 done_o,
  output logic [CHAIN_LEN-1:0] chain_q_o,
  output logic                 cg_obs_o
);
  logic se;

  scan_ctrl #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pat_count_i (pat_count_i),
    .scan_en_o   (se),
    .valid_o     (scan_valid_o),
    .done_o      (done_o)
  );

  scan_chain #(.CHAIN_LEN(CHAIN_LEN)) i_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .se_i   (se),
    .si_i   (scan_in_i),
    .d_i    (func_d_i),
    .q_o    (chain_q_o),
    .so_o   (scan_out_o)
  );

  cg_observer i_obs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cg_en_i),
    .obs_o  (cg_obs_o)
  );

  assign scan_en_o = se;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int CNT_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 scan_in_i,
  input logic                 start_i,
  input logic [CNT_W-1:0]     pat_count_i,
  input logic [CHAIN_LEN-1:0] func_d_i,
  input logic                 cg_en_i,
  input logic                 scan_out_o,
  input logic                 scan_valid_o,
  input logic                 scan_en_o,
  input logic                 done_o,
  input logic [CHAIN_LEN-1:0] chain_q_o,
  input logic                 cg_obs_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (chain_q_o == '0 && !scan_en_o && !done_o && !cg_obs_o); // R1
    end
  end

  AST_FUNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_o |=> chain_q_o == $past(func_d_i)); // R2

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |=> chain_q_o == {$past(chain_q_o[CHAIN_LEN-2:0]), $past(scan_in_i)}); // R3

  AST_CAPTURE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scan_en_o) && !done_o) |=> scan_en_o); // R5

  AST_VALID_IN_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_valid_o |-> scan_en_o); // R7

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scan_en_o); // R9

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R9

  AST_OBS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cg_obs_o == $past(cg_en_i)); // R11
endmodule

bind scan_seq_top scan_seq_chk #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scan_in_i    (scan_in_i),
  .start_i      (start_i),
  .pat_count_i  (pat_count_i),
  .func_d_i     (func_d_i),
  .cg_en_i      (cg_en_i),
  .scan_out_o   (scan_out_o),
  .scan_valid_o (scan_valid_o),
  .scan_en_o    (scan_en_o),
  .done_o       (done_o),
  .chain_q_o    (chain_q_o),
  .cg_obs_o     (cg_obs_o)
);

// File: tb/test_scan_seq_top.sv
module test_scan_seq_top;
  localparam int N  = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          scan_in = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] pat_count = '0;
  logic [N-1:0]  func_d = '0;
  logic          cg_en = 1'b0;
  logic          scan_out, scan_valid, scan_en, done;
  logic [N-1:0]  chain_q;
  logic          cg_obs;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] pats [4];
  logic [N-1:0] resp [4];

  always #10 clk = ~clk;

  scan_seq_top #(.CHAIN_LEN(N), .CNT_W(CW)) i_scan_seq_top (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .scan_in_i    (scan_in),
    .start_i      (start),
    .pat_count_i  (pat_count),
    .func_d_i     (func_d),
    .cg_en_i      (cg_en),
    .scan_out_o   (scan_out),
    .scan_valid_o (scan_valid),
    .scan_en_o    (scan_en),
    .done_o       (done),
    .chain_q_o    (chain_q),
    .cg_obs_o     (cg_obs)
  );

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    func_d = 8'hFF;
    cg_en  = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 chain", chain_q == '0, chain_q, 0);
    chk("R1 flags", {scan_en, scan_valid, done, cg_obs} == 4'b0,
        {scan_en, scan_valid, done, cg_obs}, 0);
    cg_en = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_idle();
    func_d = 8'hA5;
    scan_in = 1'b1;
    @(negedge clk);
    chk("R2 idle load", chain_q == 8'hA5 && !scan_en, chain_q, 8'hA5);
    func_d = 8'h3C;
    scan_in = 1'b0;
    @(negedge clk);
    chk("R2 idle load", chain_q == 8'h3C, chain_q, 8'h3C);
  endtask

  task automatic t_zero();
    pat_count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done", done && !scan_en, {done, scan_en}, 2'b10);
    @(negedge clk);
    chk("R10 stays", done && !scan_en, {done, scan_en}, 2'b10);
  endtask

  task automatic run(input int p);
    int k = 0;
    int j = 0;
    int cyc = 0;
    bit just_cap = 1'b0;
    pat_count = CW'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 restart", !done && scan_en, {done, scan_en}, 2'b01);
    while (!done && cyc < 1000) begin
      if (just_cap) begin
        chk("R5 captured", chain_q == resp[k-1] && scan_en, chain_q, resp[k-1]);
        just_cap = 1'b0;
      end
      if (scan_en) begin
        chk("R7 valid", scan_valid == (k > 0), scan_valid, (k > 0));
        if (k > 0)
          chk("R6 unload bit", scan_out == resp[k-1][N-1-j], scan_out, resp[k-1][N-1-j]);
        scan_in = (k < p) ? pats[k][N-1-j] : 1'b0;
        j++;
      end else begin
        chk("R4 load length", j == N, j, N);
        chk("R4 loaded", chain_q == pats[k], chain_q, pats[k]);
        chk("R7 capture", !scan_valid, scan_valid, 0);
        func_d = resp[k];
        k++;
        j = 0;
        just_cap = 1'b1;
      end
      cyc++;
      @(negedge clk);
    end
    chk("R8 cycles", cyc == (p + 1) * N + p, cyc, (p + 1) * N + p);
    chk("R6 final unload", j == N, j, N);
    chk("R5 captures", k == p, k, p);
  endtask

  task automatic t_single();
    pats[0] = 8'h81;
    resp[0] = 8'h01;
    run(1);
  endtask

  task automatic t_multi();
    pats[0] = 8'h96; resp[0] = 8'h5A;
    pats[1] = 8'h0F; resp[1] = 8'hC3;
    pats[2] = 8'hF0; resp[2] = 8'h81;
    run(3);
  endtask

  task automatic t_hold();
    func_d = 8'h66;
    for (int i = 0; i < 4; i++) begin
      scan_in = i[0];
      @(negedge clk);
      chk("R9 hold", done && !scan_en, {done, scan_en}, 2'b10);
    end
    chk("R2 in done", chain_q == 8'h66, chain_q, 8'h66);
    pats[0] = 8'h7E;
    resp[0] = 8'hE7;
    run(1);
  endtask

  task automatic t_obs();
    cg_en = 1'b1;
    @(negedge clk);
    chk("R11 high", cg_obs == 1'b1, cg_obs, 1);
    cg_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 stuck low", cg_obs == 1'b0, cg_obs, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_zero();
    t_single();
    t_multi();
    t_hold();
    t_obs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule